// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block turns an asynchronous serial bit stream into parallel characters. The line is oversampled by a one-cycle clock enable that pulses sixteen times per bit. The character format is chosen on static inputs: five to eight data bits, and parity that is off, even or odd. A completed character moves from the internal shift path into a holding register. The processor reads that register while the next character is already being shifted in.

Each received character updates a status byte. The byte has flags for data ready, overrun, parity error, framing error and line break. Two read strobes clear these flags: one for the data holding register and one for the status byte. A loopback select replaces the external serial pin with an internal transmit line, so the path can be tested without external wiring. The block drives a data-available level and an error level for an interrupt controller outside it.

Top module: `uart_rx_lsr`

## Requirements
- R1: After synchronous reset, `line_stat` and `rx_data` are zero, and both `data_avail` and `err_irq` are low.
- R2: The number of data bits is 5 + `len_sel`. Received bits are placed least significant bit first in `rx_data`, and the unused upper bits read zero.
- R3: A low level on the line starts a character only if the line is still low 8 ticks after the falling edge was first seen. A shorter low pulse produces no character.
- R4: With `par_en` high, the bit after the data is a parity bit. The parity sense is even when `par_odd` = 0 and odd when `par_odd` = 1. A mismatch sets `line_stat` bit 2, except on a break.
- R5: If the stop-bit sample is low and the character was not all low, `line_stat` bit 3 (framing error) is set.
- R6: If every sample of a character is low, including parity and stop, `line_stat` bit 4 (break) is set, an all-zero character is loaded and framing is not flagged. No new start is accepted until the line has been seen high.
- R7: If a character completes while `line_stat` bit 0 is still set, `line_stat` bit 1 (overrun) is set and the new character replaces the old one in `rx_data`.
- R8: A one-cycle `rd_stat` pulse clears bits 1 to 4 of `line_stat`. A one-cycle `rd_data` pulse clears bit 0. A flag that is set in the same cycle as its clear stays set.
- R9: When `loop_en` is high, characters are taken from `loop_txd` and `rxd_pin` has no effect.
- R10: `data_avail` equals `line_stat` bit 0, `err_irq` is the OR of bits 1 to 4, and bits 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, pulses 16 times per bit |
| rxd_pin | input | 1 | External serial input, idle high |
| loop_en | input | 1 | Select the internal loopback line |
| loop_txd | input | 1 | Internal transmit line used in loopback |
| len_sel | input | 2 | Data length select, length = 5 + len_sel |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when high, even when low |
| rd_data | input | 1 | Read strobe for the data holding register |
| rd_stat | input | 1 | Read strobe for the status byte |
| rx_data | output | 8 | Received character |
| line_stat | output | 8 | Status byte: bit 0 ready, 1 overrun, 2 parity, 3 framing, 4 break |
| data_avail | output | 1 | Character waiting |
| err_irq | output | 1 | Any error flag set |

## Verification
The bench uses the default build: 8-bit maximum character, 16x oversampling and a two-stage pin synchronizer. The tick enable pulses every second cycle, so one bit lasts 32 clocks. This small configuration makes it practical to run a structured sweep over all four lengths, all three parity modes and eight computed data patterns per combination. It also leaves room for directed runs of parity, framing, break, overrun, glitch and loopback, each checked against values the bench computes itself.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_err_t;

  localparam int ST_READY = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_PAR   = 2;
  localparam int ST_FRM   = 3;
  localparam int ST_BRK   = 4;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] char_o,
  output rx_err_t           err_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              allz;
  logic              brk_now;

  assign last_idx = IDX_W'(DATA_W - 4) + IDX_W'(len_sel);
  assign brk_now  = allz & ~rxd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      pbit   <= 1'b0;
      allz   <= 1'b0;
      done   <= 1'b0;
      char_o <= '0;
      err_o  <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!rxd) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: if (cnt == MID) begin
            cnt <= '0;
            if (!rxd) begin
              st    <= RX_DATA;
              idx   <= '0;
              shreg <= '0;
              allz  <= 1'b1;
            end else begin
              st <= RX_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_DATA: if (cnt == LAST) begin
            cnt        <= '0;
            shreg[idx] <= rxd;
            allz       <= allz & ~rxd;
            if (idx == last_idx) st <= par_en ? RX_PAR : RX_STOP;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_PAR: if (cnt == LAST) begin
            cnt  <= '0;
            pbit <= rxd;
            allz <= allz & ~rxd;
            st   <= RX_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_STOP: if (cnt == LAST) begin
            cnt        <= '0;
            done       <= 1'b1;
            char_o     <= shreg;
            err_o.brk  <= brk_now;
            err_o.ferr <= ~rxd & ~allz;
            err_o.perr <= par_en & ~brk_now & (^shreg ^ pbit ^ par_odd);
            st         <= brk_now ? RX_HOLD : RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_HOLD: if (rxd) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] char_i,
  input  rx_err_t           err_i,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] hold_q,
  output logic [7:0]        stat_q
);
  logic ready, ovr, perr, ferr, brk;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      ready  <= 1'b0;
      ovr    <= 1'b0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
      brk    <= 1'b0;
    end else begin
      if (done) hold_q <= char_i;

      if (done)         ready <= 1'b1;
      else if (rd_data) ready <= 1'b0;

      if (done && ready && !rd_data) ovr <= 1'b1;
      else if (rd_stat)              ovr <= 1'b0;

      if (done && err_i.perr) perr <= 1'b1;
      else if (rd_stat)       perr <= 1'b0;

      if (done && err_i.ferr) ferr <= 1'b1;
      else if (rd_stat)       ferr <= 1'b0;

      if (done && err_i.brk)  brk <= 1'b1;
      else if (rd_stat)       brk <= 1'b0;
    end
  end

  always_comb begin
    stat_q          = '0;
    stat_q[ST_READY] = ready;
    stat_q[ST_OVR]   = ovr;
    stat_q[ST_PAR]   = perr;
    stat_q[ST_FRM]   = ferr;
    stat_q[ST_BRK]   = brk;
  end
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick16,
  input  logic        rxd_pin,
  input  logic        loop_en,
  input  logic        loop_txd,
  input  logic [1:0]  len_sel,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic        rd_data,
  input  logic        rd_stat,
  output logic [7:0]  rx_data,
  output logic [7:0]  line_stat,
  output logic        data_avail,
  output logic        err_irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_src;
  logic                   frm_done;
  logic [DATA_W-1:0]      frm_char;
  rx_err_t                frm_err;
  logic [DATA_W-1:0]      hold_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= rxd_pin;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_pin};
      end
    end
  endgenerate

  assign rx_src = loop_en ? loop_txd : sync_q[SYNC_STAGES-1];

  uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) i_frame (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick16),
    .rxd     (rx_src),
    .len_sel (len_sel),
    .par_en  (par_en),
    .par_odd (par_odd),
    .done    (frm_done),
    .char_o  (frm_char),
    .err_o   (frm_err)
  );

  uart_rx_status #(.DATA_W(DATA_W)) i_status (
    .clk     (clk),
    .rst     (rst),
    .done    (frm_done),
    .char_i  (frm_char),
    .err_i   (frm_err),
    .rd_data (rd_data),
    .rd_stat (rd_stat),
    .hold_q  (hold_q),
    .stat_q  (line_stat)
  );

  assign rx_data    = 8'(hold_q);
  assign data_avail = line_stat[ST_READY];
  assign err_irq    = |line_stat[ST_BRK:ST_OVR];
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic       rd_data,
  input logic       rd_stat,
  input logic [7:0] line_stat
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (line_stat == 8'h00));

  a_r2_ready_source: assert property (@(posedge clk) disable iff (rst)
    $rose(line_stat[0]) |-> $past(done));

  a_r5_frame_source: assert property (@(posedge clk) disable iff (rst)
    $rose(line_stat[3]) |-> $past(done));

  a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (done && line_stat[0] && !rd_data) |=> line_stat[1]);

  a_r8_data_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !done) |=> !line_stat[0]);

  a_r8_stat_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !done) |=> (line_stat[4:1] == 4'b0000));
endmodule

bind uart_rx_lsr uart_rx_lsr_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (frm_done),
  .rd_data   (rd_data),
  .rd_stat   (rd_stat),
  .line_stat (line_stat)
);

// File: tb/test_uart_rx_lsr.sv
module test_uart_rx_lsr;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd_pin = 1'b1;
  logic       loop_en = 1'b0;
  logic       loop_txd = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_data = 1'b0;
  logic       rd_stat = 1'b0;
  logic [7:0] rx_data, line_stat;
  logic       data_avail, err_irq;

  int vectors = 0;
  int fails = 0;
  bit ended = 0;

  uart_rx_lsr i_uart_rx_lsr (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd_pin(rxd_pin),
    .loop_en(loop_en), .loop_txd(loop_txd), .len_sel(len_sel),
    .par_en(par_en), .par_odd(par_odd), .rd_data(rd_data), .rd_stat(rd_stat),
    .rx_data(rx_data), .line_stat(line_stat), .data_avail(data_avail),
    .err_irq(err_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(bit v, bit lp, int cyc);
    if (lp) loop_txd = v; else rxd_pin = v;
    repeat (cyc) @(negedge clk);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic send(logic [7:0] d, int len, int pm, bit bad_par, bit stop_v, bit lp);
    bit p;
    p = 1'b0;
    drive(1'b0, lp, BIT_CYC);
    for (int i = 0; i < len; i++) begin
      drive(d[i], lp, BIT_CYC);
      p = p ^ d[i];
    end
    if (pm != 0) drive(p ^ (pm == 2) ^ bad_par, lp, BIT_CYC);
    if (stop_v) drive(1'b1, lp, BIT_CYC);
    else        drive(1'b0, lp, 24);
    drive(1'b1, lp, 2 * BIT_CYC);
  endtask

  task automatic pulse_data();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_stat();
    rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0; @(negedge clk);
  endtask

  task automatic set_fmt(int len, int pm);
    len_sel = 2'(len - 5);
    par_en  = (pm != 0);
    par_odd = (pm == 2);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 status", line_stat, 8'h00);
    check("R1 data", rx_data, 8'h00);
    check("R1 levels", {6'b0, data_avail, err_irq}, 8'h00);

    // R2 R4 R10 sweep of length, parity and data patterns
    for (int len = 5; len <= 8; len++) begin
      for (int pm = 0; pm < 3; pm++) begin
        set_fmt(len, pm);
        for (int k = 0; k < 8; k++) begin
          logic [7:0] d, m;
          d = 8'((k * 37 + len * 11 + pm * 5 + 3) * 13);
          m = 8'((16'd1 << len) - 1);
          send(d, len, pm, 1'b0, 1'b1, 1'b0);
          check("R2 data", rx_data, d & m);
          check("R4 status clean", line_stat, 8'h01);
          check("R10 levels", {6'b0, data_avail, err_irq}, 8'h02);
          pulse_data();
          check("R8 ready cleared", line_stat, 8'h00);
        end
      end
    end

    // R4 parity mismatch, even and odd
    set_fmt(7, 1);
    send(8'h35, 7, 1, 1'b1, 1'b1, 1'b0);
    check("R4 even mismatch", line_stat, 8'h05);
    check("R4 data kept", rx_data, 8'h35);
    check("R10 error level", {7'b0, err_irq}, 8'h01);
    pulse_stat();
    check("R8 stat clear keeps ready", line_stat, 8'h01);
    pulse_data();
    set_fmt(6, 2);
    send(8'h2C, 6, 2, 1'b1, 1'b1, 1'b0);
    check("R4 odd mismatch", line_stat, 8'h05);
    pulse_stat(); pulse_data();
    check("R8 all clear", line_stat, 8'h00);

    // R5 framing error
    set_fmt(8, 0);
    send(8'h5A, 8, 0, 1'b0, 1'b0, 1'b0);
    check("R5 framing", line_stat, 8'h09);
    check("R5 data", rx_data, 8'h5A);
    pulse_stat(); pulse_data();
    check("R5 cleared", line_stat, 8'h00);

    // R6 break: long low, then hold low without a new character
    rxd_pin = 1'b0;
    repeat (12 * BIT_CYC) @(negedge clk);
    check("R6 break status", line_stat, 8'h11);
    check("R6 zero char", rx_data, 8'h00);
    pulse_stat(); pulse_data();
    repeat (30 * BIT_CYC) @(negedge clk);
    check("R6 no restart while low", line_stat, 8'h00);
    rxd_pin = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    check("R6 quiet after release", line_stat, 8'h00);
    send(8'hC3, 8, 0, 1'b0, 1'b1, 1'b0);
    check("R6 recovery data", rx_data, 8'hC3);
    check("R6 recovery status", line_stat, 8'h01);
    pulse_data();

    // R3 short glitch must not start a character
    rxd_pin = 1'b0;
    repeat (6) @(negedge clk);
    rxd_pin = 1'b1;
    repeat (14 * BIT_CYC) @(negedge clk);
    check("R3 glitch ignored", line_stat, 8'h00);

    // R7 overrun
    send(8'h11, 8, 0, 1'b0, 1'b1, 1'b0);
    send(8'h22, 8, 0, 1'b0, 1'b1, 1'b0);
    check("R7 overrun", line_stat, 8'h03);
    check("R7 newest kept", rx_data, 8'h22);
    pulse_stat();
    check("R8 overrun cleared", line_stat, 8'h01);
    pulse_data();
    check("R8 ready cleared", line_stat, 8'h00);

    // R9 loopback with the pin held low
    loop_en = 1'b1;
    rxd_pin = 1'b0;
    repeat (4 * BIT_CYC) @(negedge clk);
    check("R9 pin ignored", line_stat, 8'h00);
    send(8'hA5, 8, 0, 1'b0, 1'b1, 1'b1);
    check("R9 loop data", rx_data, 8'hA5);
    check("R9 loop status", line_stat, 8'h01);
    pulse_data();
    rxd_pin = 1'b1;
    repeat (4) @(negedge clk);
    loop_en = 1'b0;
    repeat (2 * BIT_CYC) @(negedge clk);
    check("R9 back to pin", line_stat, 8'h00);

    finish_run();
  end
endmodule